// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block keeps a small ring of transmit descriptors in local storage. It hands them one at a time to a downstream transmit engine. Each descriptor occupies eight bytes: a status word at byte offset 0 and a buffer pointer word at byte offset 4, so slot n starts at byte address 8*n. A host fills a slot through a simple register-style port. It writes the pointer first, then a status word that carries the frame length, the per-frame options and an ownership bit. Setting the ownership bit passes the slot to the block.

The block polls the slot at its current index. When the engine reports idle and the slot is owned, the block reads the status word, then the pointer word on the next cycle. It then offers pointer, length, pad request and CRC request on a valid/ready output. The offer is held unchanged until the engine accepts it. When the engine later pulses done, the block clears the ownership bit in the stored status and pulses an interrupt if the slot asked for one. It then steps to the next slot, or back to slot 0.

The output handshake follows these back-pressure rules. `frm_valid` stays high, and every payload field stays stable, until a cycle in which `frm_ready` is high. The offer is taken in that cycle and `frm_valid` falls on the next cycle. At most one frame is outstanding between acceptance and `eng_done`.

Top module: `tx_bd_ring`

## Requirements
- R1: After a synchronous reset the current index is 0. Every stored word reads 0, so no slot is owned, and `frm_valid`, `irq` and `host_err` are low.
- R2: The host byte address selects slot `host_addr[ADDR_W-1:3]` and the word `host_addr[2]` (0 = status, 1 = pointer). A read returns the stored word on `host_rdata` one cycle after `host_rd_en`. An accepted write returns no error.
- R3: A frame is offered only while the slot at the current index has its ownership bit (bit 15) set and `eng_idle` is high. Otherwise `frm_valid` stays low.
- R4: The offer carries the slot's pointer word on `frm_ptr`, status bits 31:16 on `frm_len`, status bit 12 on `frm_pad` and status bit 11 on `frm_crc`. All of them, and `frm_valid`, hold while `frm_ready` is low.
- R5: On `eng_done` for the frame in flight, the stored status of that slot loses bit 15 and keeps every other bit.
- R6: `irq` is high for exactly one cycle, the cycle after the `eng_done` that closes a frame, and only if status bit 14 of that slot was set.
- R7: After a frame completes, the index returns to 0 if the slot had its wrap bit (bit 13) set or was the last slot. Otherwise the index increases by one.
- R8: A host write to either word of an owned slot leaves both words unchanged and raises `host_err` for one cycle, the cycle after the write.
- R9: An `eng_done` pulse while no frame is in flight changes neither the index, the stored status nor `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, one cycle after the read strobe |
| host_err | output | 1 | Rejected-write pulse |
| eng_idle | input | 1 | Transmit engine can take a new frame |
| eng_done | input | 1 | One-cycle pulse: frame in flight finished |
| frm_valid | output | 1 | Frame offer valid |
| frm_ready | input | 1 | Engine accepts the offer |
| frm_ptr | output | 32 | Buffer pointer of offered frame |
| frm_len | output | 16 | Length of offered frame |
| frm_pad | output | 1 | Pad request of offered frame |
| frm_crc | output | 1 | CRC-append request of offered frame |
| irq | output | 1 | Frame-complete interrupt pulse |

## Verification
The assertions assume that `eng_done` arrives only as a single-cycle pulse. They also assume the engine treats `frm_valid` as a request it may stall, but never withdraws it. The bench's engine model raises `frm_ready` for one cycle after a programmable stall, holds `eng_idle` low while a frame is in flight, and drives `eng_done` for one cycle. The host side writes the pointer before the owning status word and otherwise drives the host port freely, including writes aimed at owned slots. A stray done pulse is issued only while no frame is in flight.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 16;
  localparam int unsigned LEN_LSB  = 16;
  localparam int unsigned RDY_POS  = 15;
  localparam int unsigned IRQ_POS  = 14;
  localparam int unsigned WRAP_POS = 13;
  localparam int unsigned PAD_POS  = 12;
  localparam int unsigned CRC_POS  = 11;

  typedef enum logic [2:0] {
    W_POLL,
    W_STAT,
    W_PTR,
    W_OFFER,
    W_BUSY
  } walk_state_e;
endpackage

// File: rtl/tbd_store.sv
module tbd_store
  import tbd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic              host_word,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_err,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [WORD_W-1:0] cur_stat,
  output logic [WORD_W-1:0] cur_ptr,
  input  logic              wb_en
);
  logic [WORD_W-1:0] stat_q [NUM_DESC];
  logic [WORD_W-1:0] ptr_q  [NUM_DESC];
  logic              host_in_range;
  logic              host_owned;

  assign host_in_range = (int'(host_idx) < NUM_DESC);
  assign host_owned    = host_in_range && stat_q[host_idx][RDY_POS];

  generate
    for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          stat_q[g] <= '0;
          ptr_q[g]  <= '0;
        end else begin
          if (wb_en && cur_idx == IDX_W'(g))
            stat_q[g][RDY_POS] <= 1'b0;
          if (host_wr_en && host_idx == IDX_W'(g) && !stat_q[g][RDY_POS]) begin
            if (host_word) ptr_q[g]  <= host_wdata;
            else           stat_q[g] <= host_wdata;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      host_err   <= 1'b0;
    end else begin
      host_err <= host_wr_en && host_owned;
      if (host_rd_en)
        host_rdata <= !host_in_range ? '0 :
                      host_word ? ptr_q[host_idx] : stat_q[host_idx];
    end
  end

  assign cur_stat = stat_q[cur_idx];
  assign cur_ptr  = ptr_q[cur_idx];

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    host_err |-> $past(host_wr_en));
endmodule

// File: rtl/tbd_walker.sv
module tbd_walker
  import tbd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_idle,
  input  logic              eng_done,
  input  logic              frm_ready,
  output logic              frm_valid,
  output logic [WORD_W-1:0] frm_ptr,
  output logic [LEN_W-1:0]  frm_len,
  output logic              frm_pad,
  output logic              frm_crc,
  output logic              irq,
  output logic [IDX_W-1:0]  cur_idx,
  input  logic [WORD_W-1:0] cur_stat,
  input  logic [WORD_W-1:0] cur_ptr,
  output logic              wb_en
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  walk_state_e       state_q;
  logic [WORD_W-1:0] stat_lat;
  logic [WORD_W-1:0] ptr_lat;
  logic [IDX_W-1:0]  idx_q;
  logic              irq_q;
  logic [10:0]       unused_stat_lo;
  logic              unused_stat_rdy;

  assign unused_stat_lo  = stat_lat[10:0];
  assign unused_stat_rdy = stat_lat[RDY_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= W_POLL;
      stat_lat <= '0;
      ptr_lat  <= '0;
      idx_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        W_POLL:  if (eng_idle && cur_stat[RDY_POS]) state_q <= W_STAT;
        W_STAT: begin
          stat_lat <= cur_stat;
          state_q  <= W_PTR;
        end
        W_PTR: begin
          ptr_lat <= cur_ptr;
          state_q <= W_OFFER;
        end
        W_OFFER: if (frm_ready) state_q <= W_BUSY;
        W_BUSY: if (eng_done) begin
          irq_q   <= stat_lat[IRQ_POS];
          idx_q   <= (stat_lat[WRAP_POS] || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          state_q <= W_POLL;
        end
        default: state_q <= W_POLL;
      endcase
    end
  end

  assign wb_en     = (state_q == W_BUSY) && eng_done;
  assign frm_valid = (state_q == W_OFFER);
  assign frm_ptr   = ptr_lat;
  assign frm_len   = stat_lat[LEN_LSB +: LEN_W];
  assign frm_pad   = stat_lat[PAD_POS];
  assign frm_crc   = stat_lat[CRC_POS];
  assign irq       = irq_q;
  assign cur_idx   = idx_q;

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!frm_valid && !irq));
  // R4
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_ptr) && $stable(frm_len)
                                   && $stable(frm_pad) && $stable(frm_crc)));
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(eng_done));
  // R9
  stray_done_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done && state_q != W_BUSY) |=> ($stable(cur_idx) && !irq));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cur_idx) < NUM_DESC);
endmodule

// File: rtl/tx_bd_ring.sv
module tx_bd_ring
  import tbd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = $clog2(NUM_DESC) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_err,
  input  logic              eng_idle,
  input  logic              eng_done,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [31:0]       frm_ptr,
  output logic [15:0]       frm_len,
  output logic              frm_pad,
  output logic              frm_crc,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]  cur_idx;
  logic [WORD_W-1:0] cur_stat;
  logic [WORD_W-1:0] cur_ptr;
  logic              wb_en;
  logic [1:0]        unused_addr_lo;

  assign unused_addr_lo = host_addr[1:0];

  tbd_store #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) i_store (
    .clk        (clk),
    .rst        (rst),
    .host_wr_en (host_wr_en),
    .host_rd_en (host_rd_en),
    .host_idx   (host_addr[ADDR_W-1:3]),
    .host_word  (host_addr[2]),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_err   (host_err),
    .cur_idx    (cur_idx),
    .cur_stat   (cur_stat),
    .cur_ptr    (cur_ptr),
    .wb_en      (wb_en)
  );

  tbd_walker #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) i_walker (
    .clk       (clk),
    .rst       (rst),
    .eng_idle  (eng_idle),
    .eng_done  (eng_done),
    .frm_ready (frm_ready),
    .frm_valid (frm_valid),
    .frm_ptr   (frm_ptr),
    .frm_len   (frm_len),
    .frm_pad   (frm_pad),
    .frm_crc   (frm_crc),
    .irq       (irq),
    .cur_idx   (cur_idx),
    .cur_stat  (cur_stat),
    .cur_ptr   (cur_ptr),
    .wb_en     (wb_en)
  );
endmodule

// File: tb/test_tx_bd_ring.sv
module test_tx_bd_ring;
  localparam int N  = 8;
  localparam int AW = $clog2(N) + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, host_wr_en, host_rd_en, host_err, eng_idle, eng_done;
  logic frm_valid, frm_ready, frm_pad, frm_crc, irq;
  logic [AW-1:0] host_addr;
  logic [31:0] host_wdata, host_rdata, frm_ptr;
  logic [15:0] frm_len;

  tx_bd_ring #(.NUM_DESC(N)) i_tx_bd_ring (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_err(host_err), .eng_idle(eng_idle), .eng_done(eng_done),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_ptr(frm_ptr),
    .frm_len(frm_len), .frm_pad(frm_pad), .frm_crc(frm_crc), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] ptr;
    logic [15:0] len;
    logic pad;
    logic crc;
    logic irq;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0, done_cnt = 0, stall = 0;
  bit auto_en = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int idx, input bit word, input logic [31:0] d, output logic err);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = AW'(idx * 8 + (word ? 4 : 0)); host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
    err = host_err;
  endtask

  task automatic host_read(input int idx, input bit word, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = AW'(idx * 8 + (word ? 4 : 0));
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [31:0] mk_stat(input logic [15:0] len, input bit rdy, input bit iq,
                                          input bit wrp, input bit pd, input bit cr);
    return {len, rdy, iq, wrp, pd, cr, 11'h0};
  endfunction

  // driver: pushes the expected item, then hands the slot over
  task automatic queue_frame(input int idx, input logic [31:0] p, input logic [15:0] len,
                             input bit iq, input bit wrp, input bit pd, input bit cr);
    logic e;
    item_t it;
    host_write(idx, 1'b1, p, e);
    check("R2 pointer write accepted", e, 0);
    it.ptr = p; it.len = len; it.pad = pd; it.crc = cr; it.irq = iq;
    sb.push_back(it);
    host_write(idx, 1'b0, mk_stat(len, 1'b1, iq, wrp, pd, cr), e);
    check("R2 status write accepted", e, 0);
  endtask

  task automatic wait_done(input int target);
    int t;
    t = 0;
    while (done_cnt < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check("R7 frames completed", done_cnt, target);
  endtask

  // monitor + engine model
  initial begin
    item_t e;
    logic [31:0] p0;
    forever begin
      @(negedge clk);
      if (auto_en && frm_valid) begin
        p0 = frm_ptr;
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          check("R4 offer held under back-pressure", {frm_valid, frm_ptr}, {1'b1, p0});
        end
        if (sb.size() == 0) begin
          check("R3 offer without queued frame", 1, 0);
          e = '0;
        end else begin
          e = sb.pop_front();
          check("R4 pointer", frm_ptr, e.ptr);
          check("R4 length", frm_len, e.len);
          check("R4 pad/crc flags", {frm_pad, frm_crc}, {e.pad, e.crc});
        end
        frm_ready = 1'b1;
        @(negedge clk);
        frm_ready = 1'b0; eng_idle = 1'b0;
        check("R4 valid falls after acceptance", frm_valid, 0);
        repeat (2) @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; eng_idle = 1'b1;
        check("R6 irq after done", irq, e.irq);
        @(negedge clk);
        check("R6 irq single cycle", irq, 0);
        done_cnt++;
      end
    end
  end

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    rst = 1; host_wr_en = 0; host_rd_en = 0; host_addr = '0; host_wdata = '0;
    eng_idle = 0; eng_done = 0; frm_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 frm_valid low", frm_valid, 0);
    check("R1 irq low", irq, 0);
    check("R1 host_err low", host_err, 0);
    host_read(0, 1'b0, d); check("R1 slot0 status zero", d, 0);
    host_read(7, 1'b1, d); check("R1 slot7 pointer zero", d, 0);

    // R2 addressing and readback
    host_write(2, 1'b1, 32'h1234_5678, e); check("R2 write ok", e, 0);
    host_write(2, 1'b0, 32'h0040_1800, e); check("R2 write ok", e, 0);
    host_write(5, 1'b1, 32'hCAFE_0004, e);
    host_read(2, 1'b1, d); check("R2 slot2 pointer", d, 32'h1234_5678);
    host_read(2, 1'b0, d); check("R2 slot2 status", d, 32'h0040_1800);
    host_read(5, 1'b1, d); check("R2 slot5 pointer", d, 32'hCAFE_0004);

    // R3 no offer while engine busy
    queue_frame(0, 32'h0000_A000, 16'h0040, 1, 0, 1, 1);
    repeat (10) @(negedge clk);
    check("R3 no offer while eng_idle low", frm_valid, 0);

    // R8 writes to owned slot rejected
    host_write(0, 1'b1, 32'hDEAD_BEEF, e); check("R8 pointer write flagged", e, 1);
    host_write(0, 1'b0, 32'h0000_0000, e); check("R8 status write flagged", e, 1);
    host_read(0, 1'b1, d); check("R8 pointer unchanged", d, 32'h0000_A000);
    host_read(0, 1'b0, d); check("R8 status unchanged", d, mk_stat(16'h0040, 1, 1, 0, 1, 1));

    // R4/R5/R6 first frame with back-pressure
    stall = 3; auto_en = 1; eng_idle = 1;
    wait_done(1);
    host_read(0, 1'b0, d); check("R5 ready cleared, rest kept", d, mk_stat(16'h0040, 0, 1, 0, 1, 1));

    // R7 wrap bit
    stall = 0;
    queue_frame(1, 32'h0000_B100, 16'h0100, 0, 0, 0, 1);
    queue_frame(2, 32'h0000_B200, 16'h05EE, 1, 1, 1, 0);
    wait_done(3);
    queue_frame(0, 32'h0000_B000, 16'h003C, 0, 0, 1, 0);
    wait_done(4);

    // R9 stray done while nothing in flight
    auto_en = 0;
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    check("R9 no irq from stray done", irq, 0);
    auto_en = 1;

    // R7 last slot returns to 0 (index now 1)
    for (int s = 1; s <= N; s++) begin
      int slot;
      slot = s % N;
      stall = s % 3;
      queue_frame(slot, 32'h0001_0000 + 32'(slot * 16'h600), 16'(40 + s * 7),
                  s[0], 0, s[1], !s[0]);
    end
    wait_done(4 + N);
    host_read(7, 1'b0, d);
    check("R5 last slot released", d[15], 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule